// File: doc/BRIEF.md
# Interrupt Context Stack Pusher

When an interrupt is accepted, this sequencer writes the processor context to the active stack. The context is a 20-bit program counter and a 16-bit flag register. The stack is reached through a 16-bit data memory port that has byte enables. The bus width the block uses follows the alignment of the stack pointer. An even stack pointer gives two full-word writes. An odd one gives four single-byte writes, so no access ever straddles a word boundary.

The frame is always four bytes long and sits directly below the sampled stack pointer. The top byte of the frame is shared: the upper flag bits and the upper program-counter bits are packed into it. The block also chooses which stack pointer is active at acceptance. When the frame is complete it pulses done, presents the new stack pointer value and strobes a write-back into the pointer it selected.

Top module: `irq_ctx_pusher`

## Requirements
- R1: The user stack pointer `usp_i` is selected only when `sw_int_i` is 1, `vec_num_i` lies in 32..63 and `u_flag_i` is 1. Every other case selects the interrupt stack pointer `isp_i`. The choice and the pointer value are sampled in the cycle `start_i` is accepted.
- R2: With an even sampled pointer SP, the block issues two writes with `mem_be_o`=2'b11. The first goes to address SP-2 with data {packed byte, flag[7:0]}. The second goes to SP-4 with data {pc[15:8], pc[7:0]}. The even address always carries bits [7:0].
- R3: With an odd sampled pointer SP, the block issues four byte writes in the address order SP-1, SP-2, SP-3, SP-4. These carry the packed byte, flag[7:0], pc[15:8] and pc[7:0] in that order. An even address uses `mem_be_o`=2'b01 with the byte on bits [7:0]. An odd address uses 2'b10 with the byte on bits [15:8]. The unused lane reads zero.
- R4: The packed byte is {flag[15:12], pc[19:16]}.
- R5: `mem_req_o` stays high from the cycle after acceptance until the final write is acknowledged. While `mem_ack_i` is low, address, data and byte enables do not change. A high `mem_ack_i` sampled at a clock edge completes the current write.
- R6: `done_o` is high for exactly one cycle, the cycle after the edge that samples the final acknowledge.
- R7: In the `done_o` cycle, `sp_new_o` equals SP-4 modulo 2^16. Exactly one of `isp_wr_o` / `usp_wr_o` is high, the one matching the pointer selected at acceptance. Outside that cycle both are low.
- R8: `busy_o` is high from acceptance through the `done_o` cycle. A `start_i` seen while busy, including in the `done_o` cycle, is ignored and leaves the write sequence in progress unchanged.
- R9: Reset (`rst_ni` low, asynchronous) clears `mem_req_o`, `done_o`, `busy_o` and both write-back strobes at once, even in the middle of a frame.
- R10: Addresses wrap modulo 2^16. For example, SP=0x0003 writes 0x0002, 0x0001, 0x0000 and then 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Interrupt accepted, begin saving |
| sw_int_i | input | 1 | Trigger is a software interrupt instruction |
| vec_num_i | input | 6 | Software interrupt number |
| u_flag_i | input | 1 | Stack select flag |
| pc_i | input | 20 | Program counter to save |
| flg_i | input | 16 | Flag register to save |
| isp_i | input | 16 | Interrupt stack pointer |
| usp_i | input | 16 | User stack pointer |
| mem_req_o | output | 1 | Write request |
| mem_addr_o | output | 16 | Byte address of the write |
| mem_wdata_o | output | 16 | Write data, bits [7:0] belong to the even byte |
| mem_be_o | output | 2 | Byte enables, bit 0 is the even byte |
| mem_ack_i | input | 1 | Memory accepted the current write |
| sp_new_o | output | 16 | Updated stack pointer, valid with done_o |
| isp_wr_o | output | 1 | Load sp_new_o into the interrupt stack pointer |
| usp_wr_o | output | 1 | Load sp_new_o into the user stack pointer |
| done_o | output | 1 | Frame complete, one cycle |
| busy_o | output | 1 | Sequence in progress |

## Verification
The even and odd pointer cases are run on both stacks, so that word versus byte lane placement is kept separate from stack selection. The interrupt numbers 31, 32 and 63 and a hardware trigger that has a high number tell apart the range test and the trigger-type test. The acknowledge delays vary between 0 and 3 cycles, which shows that the beats are held and advanced only on an acknowledge. Pointers at 0x0002 and 0x0003 expose address wrap. A start injected mid-frame or in the done cycle must leave the frame's contents unchanged.

// File: rtl/ctx_push_pkg.sv
package ctx_push_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned LANES       = 2;
  localparam int unsigned FRAME_BYTES = 4;
  localparam int unsigned WORD_BEATS  = FRAME_BYTES / LANES;
  localparam int unsigned BYTE_BEATS  = FRAME_BYTES;
  localparam int unsigned STEP_W      = $clog2(BYTE_BEATS);
  localparam int unsigned USR_VEC_LO  = 32;
  localparam int unsigned USR_VEC_HI  = 63;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_DONE  = 2'd2
  } push_state_e;

  typedef enum logic {
    SEL_ISP = 1'b0,
    SEL_USP = 1'b1
  } sp_sel_e;
endpackage

// File: rtl/ctx_sp_select.sv
module ctx_sp_select
  import ctx_push_pkg::*;
#(
  parameter int unsigned SP_W  = 16,
  parameter int unsigned VEC_W = 6
) (
  input  logic             sw_int_i,
  input  logic [VEC_W-1:0] vec_num_i,
  input  logic             u_flag_i,
  input  logic [SP_W-1:0]  isp_i,
  input  logic [SP_W-1:0]  usp_i,
  output sp_sel_e          sel_o,
  output logic [SP_W-1:0]  sp_o
);
  logic [31:0] vec_ext;
  logic        in_usr_range;

  assign vec_ext      = 32'(vec_num_i);
  assign in_usr_range = (vec_ext >= USR_VEC_LO) && (vec_ext <= USR_VEC_HI);

  always_comb begin
    if (sw_int_i && in_usr_range && u_flag_i) begin
      sel_o = SEL_USP;
      sp_o  = usp_i;
    end else begin
      sel_o = SEL_ISP;
      sp_o  = isp_i;
    end
  end
endmodule

// File: rtl/ctx_frame_gen.sv
module ctx_frame_gen
  import ctx_push_pkg::*;
#(
  parameter int unsigned SP_W  = 16,
  parameter int unsigned PC_W  = 20,
  parameter int unsigned FLG_W = 16
) (
  input  logic [SP_W-1:0]        sp_i,
  input  logic [PC_W-1:0]        pc_i,
  input  logic [FLG_W-1:0]       flg_i,
  input  logic                   odd_i,
  input  logic [STEP_W-1:0]      step_i,
  output logic [SP_W-1:0]        addr_o,
  output logic [LANES*BYTE_W-1:0] wdata_o,
  output logic [LANES-1:0]       be_o
);
  localparam int unsigned PC_HI_W  = PC_W - 2 * BYTE_W;
  localparam int unsigned FLG_HI_W = BYTE_W - PC_HI_W;

  logic [BYTE_W-1:0] fb [FRAME_BYTES];
  logic [STEP_W-1:0] idx;
  logic [BYTE_W-1:0] one_byte;

  // frame byte k lives at SP - FRAME_BYTES + k
  assign fb[0] = pc_i[BYTE_W-1:0];
  assign fb[1] = pc_i[2*BYTE_W-1:BYTE_W];
  assign fb[2] = flg_i[BYTE_W-1:0];
  assign fb[3] = {flg_i[FLG_W-1 -: FLG_HI_W], pc_i[PC_W-1 -: PC_HI_W]};

  always_comb begin
    if (odd_i) begin
      idx = STEP_W'(FRAME_BYTES - 1) - step_i;
    end else begin
      // word beats: step 0 -> upper word, step 1 -> lower word
      idx = {~step_i[0], 1'b0};
    end
    addr_o   = sp_i - SP_W'(FRAME_BYTES) + SP_W'(idx);
    one_byte = fb[idx];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      if (odd_i) begin
        be_o[l]                       = (addr_o[0] == 1'(l));
        wdata_o[l*BYTE_W +: BYTE_W]   = (addr_o[0] == 1'(l)) ? one_byte : '0;
      end else begin
        be_o[l]                       = 1'b1;
        wdata_o[l*BYTE_W +: BYTE_W]   = fb[idx | STEP_W'(l)];
      end
    end
  end
endmodule

// File: rtl/ctx_push_seq.sv
module ctx_push_seq
  import ctx_push_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              odd_i,
  input  logic              ack_i,
  output logic [STEP_W-1:0] step_o,
  output logic              load_o,
  output logic              req_o,
  output logic              done_o,
  output logic              busy_o
);
  push_state_e       state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              last_beat;

  assign last_beat = odd_i ? (step_q == STEP_W'(BYTE_BEATS - 1))
                           : (step_q == STEP_W'(WORD_BEATS - 1));

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_WRITE;
        step_d  = '0;
      end
      ST_WRITE: if (ack_i) begin
        if (last_beat) state_d = ST_DONE;
        else           step_d  = step_q + STEP_W'(1);
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign step_o = step_q;
  assign load_o = (state_q == ST_IDLE) && start_i;
  assign req_o  = (state_q == ST_WRITE);
  assign done_o = (state_q == ST_DONE);
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/irq_ctx_pusher.sv
module irq_ctx_pusher
  import ctx_push_pkg::*;
#(
  parameter int unsigned SP_W  = 16,
  parameter int unsigned PC_W  = 20,
  parameter int unsigned FLG_W = 16,
  parameter int unsigned VEC_W = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    sw_int_i,
  input  logic [VEC_W-1:0]        vec_num_i,
  input  logic                    u_flag_i,
  input  logic [PC_W-1:0]         pc_i,
  input  logic [FLG_W-1:0]        flg_i,
  input  logic [SP_W-1:0]         isp_i,
  input  logic [SP_W-1:0]         usp_i,
  output logic                    mem_req_o,
  output logic [SP_W-1:0]         mem_addr_o,
  output logic [LANES*BYTE_W-1:0] mem_wdata_o,
  output logic [LANES-1:0]        mem_be_o,
  input  logic                    mem_ack_i,
  output logic [SP_W-1:0]         sp_new_o,
  output logic                    isp_wr_o,
  output logic                    usp_wr_o,
  output logic                    done_o,
  output logic                    busy_o
);
  sp_sel_e           sel_w, cap_sel_q;
  logic [SP_W-1:0]   sp_w, cap_sp_q;
  logic [PC_W-1:0]   cap_pc_q;
  logic [FLG_W-1:0]  cap_flg_q;
  logic              cap_odd_q;
  logic              load_w;
  logic [STEP_W-1:0] step_w;

  ctx_sp_select #(.SP_W(SP_W), .VEC_W(VEC_W)) u_sel (
    .sw_int_i (sw_int_i),
    .vec_num_i(vec_num_i),
    .u_flag_i (u_flag_i),
    .isp_i    (isp_i),
    .usp_i    (usp_i),
    .sel_o    (sel_w),
    .sp_o     (sp_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_sel_q <= SEL_ISP;
      cap_sp_q  <= '0;
      cap_pc_q  <= '0;
      cap_flg_q <= '0;
      cap_odd_q <= 1'b0;
    end else if (load_w) begin
      cap_sel_q <= sel_w;
      cap_sp_q  <= sp_w;
      cap_pc_q  <= pc_i;
      cap_flg_q <= flg_i;
      cap_odd_q <= sp_w[0];
    end
  end

  ctx_push_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .odd_i  (cap_odd_q),
    .ack_i  (mem_ack_i),
    .step_o (step_w),
    .load_o (load_w),
    .req_o  (mem_req_o),
    .done_o (done_o),
    .busy_o (busy_o)
  );

  ctx_frame_gen #(.SP_W(SP_W), .PC_W(PC_W), .FLG_W(FLG_W)) u_frame (
    .sp_i   (cap_sp_q),
    .pc_i   (cap_pc_q),
    .flg_i  (cap_flg_q),
    .odd_i  (cap_odd_q),
    .step_i (step_w),
    .addr_o (mem_addr_o),
    .wdata_o(mem_wdata_o),
    .be_o   (mem_be_o)
  );

  assign sp_new_o = cap_sp_q - SP_W'(FRAME_BYTES);
  assign isp_wr_o = done_o && (cap_sel_q == SEL_ISP);
  assign usp_wr_o = done_o && (cap_sel_q == SEL_USP);
endmodule

// File: rtl/ctx_pusher_chk.sv
module ctx_pusher_chk #(
  parameter int unsigned SP_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_req_o,
  input logic            mem_ack_i,
  input logic [SP_W-1:0] mem_addr_o,
  input logic [15:0]     mem_wdata_o,
  input logic [1:0]      mem_be_o,
  input logic            done_o,
  input logic            busy_o,
  input logic            isp_wr_o,
  input logic            usp_wr_o,
  input logic [SP_W-1:0] sp_new_o,
  input logic            odd_q
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_be_o)); // R5
  AST_WORD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !odd_q |-> mem_be_o == 2'b11 && !mem_addr_o[0]); // R2
  AST_BYTE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && odd_q |-> $countones(mem_be_o) == 1 && mem_be_o[1] == mem_addr_o[0]); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_req_o && mem_ack_i)); // R6
  AST_WB_ONE_STACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({isp_wr_o, usp_wr_o}) && ((isp_wr_o || usp_wr_o) == done_o)); // R7
  AST_SP_MATCHES_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sp_new_o == $past(mem_addr_o)); // R7
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o); // R8
endmodule

bind irq_ctx_pusher ctx_pusher_chk #(.SP_W(SP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_ack_i  (mem_ack_i),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_be_o   (mem_be_o),
  .done_o     (done_o),
  .busy_o     (busy_o),
  .isp_wr_o   (isp_wr_o),
  .usp_wr_o   (usp_wr_o),
  .sp_new_o   (sp_new_o),
  .odd_q      (cap_odd_q)
);

// File: tb/tb_irq_ctx_pusher.sv
module tb_irq_ctx_pusher;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        sw;
    logic [5:0]  num;
    logic        u;
    logic [15:0] isp;
    logic [15:0] usp;
    logic [19:0] pc;
    logic [15:0] flg;
    logic        exp_user;
    logic [15:0] exp_sp;
    logic [1:0]  dly;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd0,  1'b1, 16'h1000, 16'h7000, 20'h5A1B2, 16'hC3D4, 1'b0, 16'h0FFC, 2'd0},
    '{1'b0, 6'd45, 1'b1, 16'h2001, 16'h7000, 20'h12345, 16'h9876, 1'b0, 16'h1FFD, 2'd1},
    '{1'b1, 6'd40, 1'b1, 16'h1000, 16'h3002, 20'hFEDCB, 16'hA5A5, 1'b1, 16'h2FFE, 2'd2},
    '{1'b1, 6'd33, 1'b1, 16'h1000, 16'h4005, 20'h00F0F, 16'hF000, 1'b1, 16'h4001, 2'd0},
    '{1'b1, 6'd32, 1'b0, 16'h0FFE, 16'h4000, 20'h81234, 16'h1234, 1'b0, 16'h0FFA, 2'd1},
    '{1'b1, 6'd31, 1'b1, 16'h0801, 16'h4000, 20'h77777, 16'h8888, 1'b0, 16'h07FD, 2'd0},
    '{1'b1, 6'd63, 1'b1, 16'h0800, 16'h5FFF, 20'hABCDE, 16'h5F00, 1'b1, 16'h5FFB, 2'd3},
    '{1'b1, 6'd0,  1'b1, 16'h0002, 16'h6000, 20'h33C3C, 16'h0AB0, 1'b0, 16'hFFFE, 2'd0},
    '{1'b0, 6'd0,  1'b0, 16'h0003, 16'h6000, 20'hC0001, 16'hFFFF, 1'b0, 16'hFFFF, 2'd1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        sw_int_i = 1'b0;
  logic [5:0]  vec_num_i = '0;
  logic        u_flag_i = 1'b0;
  logic [19:0] pc_i = '0;
  logic [15:0] flg_i = '0;
  logic [15:0] isp_i = '0;
  logic [15:0] usp_i = '0;
  logic        mem_ack_i = 1'b0;
  logic        mem_req_o;
  logic [15:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic [1:0]  mem_be_o;
  logic [15:0] sp_new_o;
  logic        isp_wr_o, usp_wr_o, done_o, busy_o;

  int n_chk  = 0;
  int n_fail = 0;

  logic [15:0] ea [4];
  logic [15:0] ed [4];
  logic [1:0]  eb [4];
  int          en;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  irq_ctx_pusher dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .sw_int_i(sw_int_i),
    .vec_num_i(vec_num_i), .u_flag_i(u_flag_i), .pc_i(pc_i), .flg_i(flg_i),
    .isp_i(isp_i), .usp_i(usp_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o), .mem_ack_i(mem_ack_i),
    .sp_new_o(sp_new_o), .isp_wr_o(isp_wr_o), .usp_wr_o(usp_wr_o),
    .done_o(done_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected beats, derived from the requirement text
  task automatic build_exp(input logic [15:0] sp, input logic [19:0] pc, input logic [15:0] flg);
    logic [7:0] pk;
    logic [7:0] by [4];
    pk = {flg[15:12], pc[19:16]};           // R4
    if (!sp[0]) begin                       // R2
      en = 2;
      ea[0] = sp - 16'd2; ed[0] = {pk, flg[7:0]};     eb[0] = 2'b11;
      ea[1] = sp - 16'd4; ed[1] = {pc[15:8], pc[7:0]}; eb[1] = 2'b11;
    end else begin                          // R3
      en = 4;
      by[0] = pk; by[1] = flg[7:0]; by[2] = pc[15:8]; by[3] = pc[7:0];
      for (int k = 0; k < 4; k++) begin
        ea[k] = sp - 16'(k + 1);
        if (ea[k][0]) begin ed[k] = {by[k], 8'h00}; eb[k] = 2'b10; end
        else          begin ed[k] = {8'h00, by[k]}; eb[k] = 2'b01; end
      end
    end
  endtask

  task automatic run_push(input vec_t v, input bit inj);
    logic [15:0] sp;
    string       mtag;
    sp = v.exp_user ? v.usp : v.isp;      // R1
    build_exp(sp, v.pc, v.flg);
    mtag = sp[0] ? "R3 R4 R10" : "R2 R4 R10";
    @(negedge clk_i);
    sw_int_i = v.sw; vec_num_i = v.num; u_flag_i = v.u;
    isp_i = v.isp; usp_i = v.usp; pc_i = v.pc; flg_i = v.flg;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < en; k++) begin
      for (int dd = 0; dd <= int'(v.dly); dd++) begin
        chk(mem_req_o && busy_o && !done_o, "R5 R8 req/busy during frame",
            {mem_req_o, busy_o, done_o}, 3'b110);
        chk({mem_addr_o, mem_wdata_o, mem_be_o} == {ea[k], ed[k], eb[k]},
            (dd == 0) ? mtag : "R5 hold while no ack",
            {mem_addr_o, mem_wdata_o, mem_be_o}, {ea[k], ed[k], eb[k]});
        if (inj && k == 0 && dd == 0) begin    // R8: start while busy
          start_i = 1'b1; pc_i = ~v.pc; flg_i = ~v.flg;
          isp_i = v.isp ^ 16'h0101; usp_i = v.usp ^ 16'h0101; sw_int_i = ~v.sw;
        end
        if (dd == int'(v.dly)) mem_ack_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        mem_ack_i = 1'b0;
      end
    end
    chk(done_o && !mem_req_o, "R6 done after final ack", {done_o, mem_req_o}, 2'b10);
    chk(sp_new_o == v.exp_sp, "R7 R10 new stack pointer", sp_new_o, v.exp_sp);
    chk({usp_wr_o, isp_wr_o} == {v.exp_user, ~v.exp_user}, "R1 R7 write-back target",
        {usp_wr_o, isp_wr_o}, {v.exp_user, ~v.exp_user});
    if (inj) start_i = 1'b1;                   // R8: start in done cycle
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!done_o && !busy_o && !mem_req_o && !isp_wr_o && !usp_wr_o,
        inj ? "R8 start in done cycle ignored" : "R6 done lasts one cycle",
        {done_o, busy_o, mem_req_o, isp_wr_o, usp_wr_o}, 5'b0);
    @(negedge clk_i);
    chk(!mem_req_o && !busy_o, "R8 stays idle", {mem_req_o, busy_o}, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R6 watchdog expired act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    chk(!mem_req_o && !done_o && !busy_o && !isp_wr_o && !usp_wr_o, "R9 reset state",
        {mem_req_o, done_o, busy_o, isp_wr_o, usp_wr_o}, 5'b0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) run_push(VECS[i], 1'b0);

    // start ignored while busy, even and odd frames
    run_push(VECS[2], 1'b1);
    run_push(VECS[3], 1'b1);

    // asynchronous reset in the middle of a frame
    @(negedge clk_i);
    sw_int_i = 1'b0; isp_i = 16'h1235; pc_i = 20'h11111; flg_i = 16'h2222;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(mem_req_o, "R5 request before reset", mem_req_o, 1'b1);
    #2 rst_ni = 1'b0;
    #1;
    chk(!mem_req_o && !busy_o && !done_o, "R9 reset mid-frame",
        {mem_req_o, busy_o, done_o}, 3'b000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!mem_req_o && !busy_o, "R9 idle after reset", {mem_req_o, busy_o}, 2'b00);

    // run one frame after reset to confirm recovery
    run_push(VECS[8], 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule